// File: doc/BRIEF.md
# Per-PC Insertion Override Predictor

This block sits beside a last-level cache and decides how a missing line should be inserted. Each miss presents the program counter of the load together with the cache's current global insertion mode, which is either LRU insertion or bypassing bimodal insertion (BBIP). The PC and the mode bit are joined into one key, and that key is searched across a fully associative table. When the key is present, the saturating counter stored with it sets the policy, and this can override the global mode in either direction. When the key is absent, the global mode is returned unchanged.

The table is trained by the sampled tracker sets of the cache. A tracker-set miss may ask for an entry to be allocated. The table index that comes back is kept in the cache line alongside a reuse flag. Later, a reuse of that line reports the index on the reuse channel, and an eviction of a line that was never reused reports it on the dead channel. A counter that drifts upward means the lines of that PC die unused, and the block then steers them to BBIP. A counter that drifts downward means the lines are reused, and the block steers them to LRU. Entries are replaced in round-robin order.

Top module: `iop_predictor`

## Requirements
- R1: After reset no entry is valid, so every lookup misses (`res_hit`=0) until an entry has been allocated.
- R2: The search key is the mode bit `lk_default` placed above the PC. The same PC under the other mode is a different key and misses.
- R3: Each cycle with `lk_valid`=1 produces exactly one result with `res_valid`=1 in the following cycle. A cycle without a request produces no result.
- R4: On a miss the result carries `res_hit`=0 and `res_policy` equal to the request's `lk_default`. Policy encoding: 0 = LRU insertion, 1 = BBIP.
- R5: A miss with `lk_alloc`=1 writes the key into the entry named by a round-robin pointer. The pointer starts at 0 after reset and wraps from ENTRIES-1 back to 0. The result index is that entry, the new counter is 32, and the key that was overwritten no longer hits. A miss with `lk_alloc`=0 allocates nothing and returns index 0.
- R6: On a hit, `res_hit`=1, `res_index` is the matching entry, and `res_policy` is bit 5 (the MSB) of that entry's 6-bit counter.
- R7: A dead-eviction event (`dead_valid`, `dead_idx`) increments the entry's counter, which saturates at 63.
- R8: A reuse event (`reuse_valid`, `reuse_idx`) decrements the entry's counter, which saturates at 0.
- R9: A reuse event and a dead event for the same index in the same cycle cancel, and the counter keeps its value.
- R10: A training event that lands in the same cycle as a lookup hitting the same entry is applied before the lookup, so the result reflects the updated counter.
- R11: A hit with `lk_alloc`=1 allocates nothing and does not advance the round-robin pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_pc | input | PC_W | PC of the missing load |
| lk_default | input | 1 | Current global insertion mode (0 LRU, 1 BBIP) |
| lk_alloc | input | 1 | Request comes from a tracker set; allocate on miss |
| reuse_valid | input | 1 | A tracker line was reused |
| reuse_idx | input | IDX_W | Table index stored in the reused line |
| dead_valid | input | 1 | A never-reused tracker line was evicted |
| dead_idx | input | IDX_W | Table index stored in the evicted line |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| res_hit | output | 1 | Key was found in the table |
| res_policy | output | 1 | Insertion policy to use (0 LRU, 1 BBIP) |
| res_index | output | IDX_W | Hit or newly allocated entry, for the line to keep |

## Verification
The bench drives the counter of one entry into both saturation limits and then walks it back, so that a counter that wraps instead of clamping leaves the MSB on the wrong side and shows up as a wrong policy. It sends reuse and dead events for the same index in one cycle, and a training event in the same cycle as a lookup. A design that let one event win would flip the policy, and a design that read the stale counter would return the old one. It allocates enough distinct keys to make the pointer wrap. This exposes a pointer that skips, does not wrap, or advances on a hit, and it also shows a victim key that still hits after being overwritten. It also looks up a PC under the opposite mode, so a key that drops the mode bit would produce a false hit.

// File: rtl/iop_pkg.sv
package iop_pkg;
  typedef enum logic {
    POL_LRU  = 1'b0,
    POL_BBIP = 1'b1
  } policy_e;
endpackage

// File: rtl/iop_key_cam.sv
module iop_key_cam #(
  parameter int ENTRIES = 512,
  parameter int KEY_W   = 65,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [KEY_W-1:0] key_in,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx
);
  logic [KEY_W-1:0]   keys [ENTRIES];
  logic [ENTRIES-1:0] vld;
  logic [ENTRIES-1:0] match;

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else if (wr_en) vld[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) keys[wr_idx] <= key_in;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = vld[g] && (keys[g] == key_in);
  end

  // keys are unique, so at most one line matches; lowest index wins anyway
  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit = |match;
endmodule

// File: rtl/iop_cnt_bank.sv
module iop_cnt_bank #(
  parameter int ENTRIES = 512,
  parameter int CNT_W   = 6,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             up_v,
  input  logic [IDX_W-1:0] up_idx,
  input  logic             dn_v,
  input  logic [IDX_W-1:0] dn_idx,
  input  logic             init_v,
  input  logic [IDX_W-1:0] init_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_msb
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_MID = {1'b1, {(CNT_W-1){1'b0}}};

  logic [CNT_W-1:0] cnt [ENTRIES];
  logic             clash, up_eff, dn_eff;
  logic [CNT_W-1:0] rd_fwd;

  function automatic logic [CNT_W-1:0] step_up(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + CNT_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] step_dn(input logic [CNT_W-1:0] v);
    return (v == '0) ? v : v - CNT_W'(1);
  endfunction

  assign clash  = up_v && dn_v && (up_idx == dn_idx);
  assign up_eff = up_v && !clash;
  assign dn_eff = dn_v && !clash;

  always_ff @(posedge clk) begin
    if (up_eff) cnt[up_idx] <= step_up(cnt[up_idx]);
    if (dn_eff) cnt[dn_idx] <= step_dn(cnt[dn_idx]);
    if (init_v) cnt[init_idx] <= CNT_MID;
  end

  // training of this cycle is seen by the lookup of this cycle
  always_comb begin
    rd_fwd = cnt[rd_idx];
    if (up_eff && (up_idx == rd_idx)) rd_fwd = step_up(rd_fwd);
    if (dn_eff && (dn_idx == rd_idx)) rd_fwd = step_dn(rd_fwd);
  end

  assign rd_msb = rd_fwd[CNT_W-1];
endmodule

// File: rtl/iop_rr_ptr.sv
module iop_rr_ptr #(
  parameter int ENTRIES = 512,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (adv) ptr <= (ptr == IDX_W'(ENTRIES - 1)) ? '0 : ptr + IDX_W'(1);
  end
endmodule

// File: rtl/iop_predictor.sv
module iop_predictor
  import iop_pkg::*;
#(
  parameter int ENTRIES = 512,
  parameter int PC_W    = 64,
  parameter int CNT_W   = 6,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int KEY_W  = PC_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [PC_W-1:0]  lk_pc,
  input  logic             lk_default,
  input  logic             lk_alloc,
  input  logic             reuse_valid,
  input  logic [IDX_W-1:0] reuse_idx,
  input  logic             dead_valid,
  input  logic [IDX_W-1:0] dead_idx,
  output logic             res_valid,
  output logic             res_hit,
  output logic             res_policy,
  output logic [IDX_W-1:0] res_index
);
  logic [KEY_W-1:0] key;
  logic             hit;
  logic [IDX_W-1:0] hit_idx;
  logic [IDX_W-1:0] ptr;
  logic             do_alloc;
  logic             cnt_msb;
  policy_e          pol_next;
  logic [IDX_W-1:0] idx_next;

  assign key      = {lk_default, lk_pc};
  assign do_alloc = lk_valid && lk_alloc && !hit;

  iop_key_cam #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) i_cam (
    .clk    (clk),
    .rst    (rst),
    .key_in (key),
    .wr_en  (do_alloc),
    .wr_idx (ptr),
    .hit    (hit),
    .hit_idx(hit_idx)
  );

  iop_cnt_bank #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) i_cnt (
    .clk     (clk),
    .up_v    (dead_valid),
    .up_idx  (dead_idx),
    .dn_v    (reuse_valid),
    .dn_idx  (reuse_idx),
    .init_v  (do_alloc),
    .init_idx(ptr),
    .rd_idx  (hit_idx),
    .rd_msb  (cnt_msb)
  );

  iop_rr_ptr #(.ENTRIES(ENTRIES)) i_ptr (
    .clk(clk),
    .rst(rst),
    .adv(do_alloc),
    .ptr(ptr)
  );

  always_comb begin
    pol_next = hit ? policy_e'(cnt_msb) : policy_e'(lk_default);
    if (hit)           idx_next = hit_idx;
    else if (do_alloc) idx_next = ptr;
    else               idx_next = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_hit    <= 1'b0;
      res_policy <= 1'b0;
      res_index  <= '0;
    end else begin
      res_valid <= lk_valid;
      if (lk_valid) begin
        res_hit    <= hit;
        res_policy <= pol_next;
        res_index  <= idx_next;
      end
    end
  end
endmodule

// File: rtl/iop_checker.sv
module iop_checker #(
  parameter int ENTRIES = 512,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input logic             clk,
  input logic             rst,
  input logic             lk_valid,
  input logic             lk_default,
  input logic             lk_alloc,
  input logic             res_valid,
  input logic             res_hit,
  input logic             res_policy,
  input logic [IDX_W-1:0] res_index
);
  logic             alloc_q, seen;
  logic [IDX_W-1:0] last;
  logic             alloc_res;
  logic [IDX_W-1:0] nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      alloc_q <= 1'b0;
      seen    <= 1'b0;
      last    <= '0;
    end else begin
      alloc_q <= lk_valid && lk_alloc;
      if (alloc_res) begin
        seen <= 1'b1;
        last <= res_index;
      end
    end
  end

  assign alloc_res = res_valid && !res_hit && alloc_q;
  assign nxt = (last == IDX_W'(ENTRIES - 1)) ? '0 : last + IDX_W'(1);

  AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (rst) lk_valid |=> res_valid); // R3
  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (rst) !lk_valid |=> !res_valid); // R3
  AST_MISS_KEEPS_DEFAULT: assert property (@(posedge clk) disable iff (rst) lk_valid |=> (res_hit || res_policy == $past(lk_default))); // R4
  AST_NOALLOC_ZERO_INDEX: assert property (@(posedge clk) disable iff (rst) (lk_valid && !lk_alloc) |=> (res_hit || res_index == '0)); // R5
  AST_RR_FIRST_SLOT: assert property (@(posedge clk) disable iff (rst) (alloc_res && !seen) |-> (res_index == '0)); // R5
  AST_RR_NEXT_SLOT: assert property (@(posedge clk) disable iff (rst) (alloc_res && seen) |-> (res_index == nxt)); // R11
endmodule

bind iop_predictor iop_checker #(.ENTRIES(ENTRIES)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .lk_valid  (lk_valid),
  .lk_default(lk_default),
  .lk_alloc  (lk_alloc),
  .res_valid (res_valid),
  .res_hit   (res_hit),
  .res_policy(res_policy),
  .res_index (res_index)
);

// File: tb/test_iop_predictor.sv
module test_iop_predictor;
  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES    = 512;
  localparam int PC_W       = 64;
  localparam int IDX_W      = $clog2(ENTRIES);

  logic             clk = 1'b0;
  logic             rst;
  logic             lk_valid, lk_default, lk_alloc;
  logic [PC_W-1:0]  lk_pc;
  logic             reuse_valid, dead_valid;
  logic [IDX_W-1:0] reuse_idx, dead_idx;
  logic             res_valid, res_hit, res_policy;
  logic [IDX_W-1:0] res_index;

  int total = 0;
  int bad   = 0;
  logic [IDX_W+1:0] q_exp [$];
  string            q_req [$];

  iop_predictor #(.ENTRIES(ENTRIES), .PC_W(PC_W)) i_iop_predictor (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_default(lk_default), .lk_alloc(lk_alloc),
    .reuse_valid(reuse_valid), .reuse_idx(reuse_idx),
    .dead_valid(dead_valid), .dead_idx(dead_idx),
    .res_valid(res_valid), .res_hit(res_hit), .res_policy(res_policy), .res_index(res_index)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops one expectation per result
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (q_exp.size() == 0) begin
        check("R3 result without request", 1, 0);
      end else begin
        check(q_req.pop_front(), {res_hit, res_policy, res_index}, q_exp.pop_front());
      end
    end
  end

  task automatic op(bit lk, logic [PC_W-1:0] pc, bit dflt, bit alloc,
                    bit rv, int ri, bit dv, int di,
                    bit ehit, bit epol, int eidx, string req);
    @(negedge clk);
    lk_valid    = lk;
    lk_pc       = pc;
    lk_default  = dflt;
    lk_alloc    = alloc;
    reuse_valid = rv;
    reuse_idx   = IDX_W'(ri);
    dead_valid  = dv;
    dead_idx    = IDX_W'(di);
    if (lk) begin
      q_exp.push_back({ehit, epol, IDX_W'(eidx)});
      q_req.push_back(req);
    end
    @(negedge clk);
    lk_valid    = 1'b0;
    reuse_valid = 1'b0;
    dead_valid  = 1'b0;
  endtask

  task automatic look(logic [PC_W-1:0] pc, bit dflt, bit alloc,
                      bit ehit, bit epol, int eidx, string req);
    op(1, pc, dflt, alloc, 0, 0, 0, 0, ehit, epol, eidx, req);
  endtask

  task automatic train(bit rv, bit dv, int idx);
    op(0, '0, 0, 0, rv, idx, dv, idx, 0, 0, 0, "");
  endtask

  localparam logic [PC_W-1:0] PC_A = 64'hA000;
  localparam logic [PC_W-1:0] PC_B = 64'hB000;

  initial begin
    repeat (100000) @(posedge clk);
    check("watchdog expired", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    lk_valid = 0; lk_pc = '0; lk_default = 0; lk_alloc = 0;
    reuse_valid = 0; reuse_idx = '0; dead_valid = 0; dead_idx = '0;
    repeat (3) @(negedge clk);
    check("R1 reset res_valid", res_valid, 0);
    rst = 1'b0;

    look(PC_A, 0, 0, 0, 0, 0, "R1 R4 empty table miss LRU");
    look(PC_B, 1, 0, 0, 1, 0, "R4 miss returns BBIP default");
    look(PC_A, 0, 1, 0, 0, 0, "R5 first allocation slot 0");
    look(PC_A, 0, 1, 1, 1, 0, "R6 R11 hit new entry counter 32");
    look(PC_A, 1, 0, 0, 1, 0, "R2 other mode is different key");

    train(1, 0, 0);                                   // 31
    look(PC_A, 0, 0, 1, 0, 0, "R8 reuse lowers counter");
    train(0, 1, 0);                                   // 32
    look(PC_A, 0, 0, 1, 1, 0, "R7 dead raises counter");
    train(1, 1, 0);                                   // stays 32
    look(PC_A, 0, 0, 1, 1, 0, "R9 same-cycle events cancel");
    op(1, PC_A, 0, 0, 1, 0, 0, 0, 1, 0, 0, "R10 reuse applied before lookup"); // 31
    op(1, PC_A, 0, 0, 0, 0, 1, 0, 1, 1, 0, "R10 dead applied before lookup");  // 32

    for (int i = 0; i < 40; i++) train(0, 1, 0);      // 63 saturated
    for (int i = 0; i < 31; i++) train(1, 0, 0);      // 32
    look(PC_A, 0, 0, 1, 1, 0, "R7 clamp at 63");
    train(1, 0, 0);                                   // 31
    look(PC_A, 0, 0, 1, 0, 0, "R7 clamp at 63 step down");

    for (int i = 0; i < 40; i++) train(1, 0, 0);      // 0 saturated
    for (int i = 0; i < 31; i++) train(0, 1, 0);      // 31
    look(PC_A, 1, 0, 0, 1, 0, "R2 mode BBIP key absent");
    look(PC_A, 0, 0, 1, 0, 0, "R8 clamp at 0");
    train(0, 1, 0);                                   // 32
    look(PC_A, 0, 0, 1, 1, 0, "R8 clamp at 0 step up");

    for (int i = 0; i < ENTRIES; i++)
      look(64'h100000 + 64'(i), 0, 1, 0, 0, (i + 1) % ENTRIES, "R5 R11 round-robin slot");
    look(PC_A, 0, 0, 0, 0, 0, "R5 victim key no longer hits");
    look(64'h100000, 0, 0, 1, 1, 1, "R5 new entry starts at 32");
    look(64'h100000 + 64'(ENTRIES - 1), 0, 0, 1, 1, 0, "R5 wrapped entry hits");

    repeat (4) @(negedge clk);
    check("R3 every request answered once", q_exp.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule